// File: doc/BRIEF.md
# Reciprocal Frequency Counter with Armed Gate

This block measures the frequency or period of an input signal against a reference clock. It does not open its gate in step with the input. A start pulse arms the block, and the first rising edge of the input after that becomes the start of the measurement. A gate timer then runs for a programmed number of reference cycles. When the gate closes, the block arms for the stop, and the next rising input edge ends the measurement.

The block reports two numbers. N is the count of input rising edges after the start edge, up to and including the stop edge. T is the count of reference cycles between the start edge and the stop edge. Both ends of the interval sit on input edges, so N/T times the reference frequency gives the input frequency with no plus-or-minus one count error. The division is left to the consumer. Results leave on a valid/ready stream. If either armed phase waits too long for an input edge, the block gives up, raises a timeout pulse and produces no result.

Top module: `recip_freq_meter`

## Requirements
- R1: After reset, res_valid_o and timeout_o are low, res_events_o and res_ticks_o are zero, and the block is idle.
- R2: A start_i pulse is accepted only while the block is idle. A pulse that arrives during a measurement or while a result waits does not start a second measurement.
- R3: The input passes through two synchronizing flops and an edge detector, and only low-to-high transitions count. A constant level counts as no edge, and this includes an input that is already high when the block is armed. The input must stay high for at least 2 cycles and low for at least 2 cycles.
- R4: After a start is accepted, the first rising input edge starts the measurement, and T counts from that edge. For a periodic input of P cycles, T equals N*P exactly.
- R5: The gate lasts G = max(gate_len_i, 1) reference cycles after the start edge. An edge inside the gate counts in N. This includes an edge in the gate's last cycle, and such an edge does not stop the measurement. The stop edge is the first edge after the gate closes, so for a periodic input N = floor(G/P) + 1.
- R6: A result has N >= 1, and T is at least N.
- R7: res_valid_o rises in the cycle after the stop edge is detected. res_valid_o, res_events_o and res_ticks_o hold steady until res_ready_i is high, and the transfer happens on the clock edge where res_valid_o and res_ready_i are both high. In the next cycle res_valid_o is low and the block is idle.
- R8: In either armed phase, if no rising edge arrives within max(timeout_len_i, 1) cycles of arming, the block returns to idle. timeout_o is then high for exactly one cycle, and no result is produced. For the start phase, the timeout pulse appears on the clock edge max(timeout_len_i,1) edges after the edge that accepted the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a measurement (accepted only when idle) |
| gate_len_i | input | GATE_W | Requested gate length in reference cycles (0 acts as 1) |
| timeout_len_i | input | GATE_W | Maximum wait for an edge in either armed phase (0 acts as 1) |
| sig_i | input | 1 | Asynchronous signal under measurement |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Consumer accepts the result |
| res_events_o | output | GATE_W+2 | Rising input edges N in the measured interval |
| res_ticks_o | output | GATE_W+2 | Reference cycles T in the measured interval |
| timeout_o | output | 1 | One-cycle pulse when a measurement is abandoned |

## Verification
The bench uses periods whose edges land exactly on the last cycle of the gate. A design that treats that edge as the stop would report one period too few. It also uses a zero gate length, which must act as one cycle. A design that handled this wrongly would either hang or return N of zero.

Held-off ready checks that the result stays frozen while it waits. A stray start during a measurement checks that no second result appears. A pulse-free input and a steadily high input must both end in a timeout at the exact expected cycle. A single lone pulse must time out in the stop phase. A level-sensitive or unsynchronized design would show up as wrong N or T values, or as a missing timeout.

// File: rtl/rfm_pkg.sv
package rfm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM_START,
    ST_COUNT,
    ST_ARM_STOP,
    ST_DONE
  } rfm_state_e;
endpackage

// File: rtl/rfm_edge_sync.sv
module rfm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);
  // sh[STAGES-1] is the synchronized level; sh[STAGES] is its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], sig_i};
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/rfm_seq.sv
module rfm_seq
  import rfm_pkg::*;
#(
  parameter int GATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [GATE_W-1:0] gate_len_i,
  input  logic [GATE_W-1:0] timeout_len_i,
  input  logic              rise_i,
  input  logic              res_ready_i,
  output rfm_state_e        state_o,
  output logic              start_hit_o,
  output logic              timeout_o
);
  rfm_state_e        state;
  logic [GATE_W-1:0] gcnt;
  logic [GATE_W-1:0] wcnt;
  logic [GATE_W-1:0] wait_last;
  logic              wait_over;

  assign wait_last   = (timeout_len_i == '0) ? '0 : timeout_len_i - GATE_W'(1);
  assign wait_over   = (wcnt >= wait_last);
  assign start_hit_o = (state == ST_ARM_START) && rise_i;
  assign state_o     = state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      gcnt      <= '0;
      wcnt      <= '0;
      timeout_o <= 1'b0;
    end else begin
      timeout_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            state <= ST_ARM_START;
            wcnt  <= '0;
          end
        end
        ST_ARM_START: begin
          if (rise_i) begin
            state <= ST_COUNT;
            gcnt  <= gate_len_i;
          end else if (wait_over) begin
            state     <= ST_IDLE;
            timeout_o <= 1'b1;
          end else begin
            wcnt <= wcnt + GATE_W'(1);
          end
        end
        ST_COUNT: begin
          if (gcnt <= GATE_W'(1)) begin
            state <= ST_ARM_STOP;
            wcnt  <= '0;
          end else begin
            gcnt <= gcnt - GATE_W'(1);
          end
        end
        ST_ARM_STOP: begin
          if (rise_i) begin
            state <= ST_DONE;
          end else if (wait_over) begin
            state     <= ST_IDLE;
            timeout_o <= 1'b1;
          end else begin
            wcnt <= wcnt + GATE_W'(1);
          end
        end
        ST_DONE: begin
          if (res_ready_i) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rfm_accum.sv
module rfm_accum
  import rfm_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rfm_state_e       state_i,
  input  logic             rise_i,
  input  logic             start_hit_i,
  output logic [CNT_W-1:0] events_o,
  output logic [CNT_W-1:0] ticks_o
);
  logic active;
  assign active = (state_i == ST_COUNT) || (state_i == ST_ARM_STOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      events_o <= '0;
      ticks_o  <= '0;
    end else if (start_hit_i) begin
      events_o <= '0;
      ticks_o  <= '0;
    end else if (active) begin
      ticks_o  <= ticks_o + CNT_W'(1);
      if (rise_i) events_o <= events_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/recip_freq_meter.sv
module recip_freq_meter
  import rfm_pkg::*;
#(
  parameter int GATE_W     = 16,
  parameter int SYNC_DEPTH = 2,
  localparam int CNT_W     = GATE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [GATE_W-1:0] gate_len_i,
  input  logic [GATE_W-1:0] timeout_len_i,
  input  logic              sig_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [CNT_W-1:0]  res_events_o,
  output logic [CNT_W-1:0]  res_ticks_o,
  output logic              timeout_o
);
  logic       rise;
  logic       start_hit;
  rfm_state_e state;

  rfm_edge_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (sig_i),
    .rise_o (rise)
  );

  rfm_seq #(.GATE_W(GATE_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .gate_len_i    (gate_len_i),
    .timeout_len_i (timeout_len_i),
    .rise_i        (rise),
    .res_ready_i   (res_ready_i),
    .state_o       (state),
    .start_hit_o   (start_hit),
    .timeout_o     (timeout_o)
  );

  rfm_accum #(.CNT_W(CNT_W)) u_acc (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_i     (state),
    .rise_i      (rise),
    .start_hit_i (start_hit),
    .events_o    (res_events_o),
    .ticks_o     (res_ticks_o)
  );

  assign res_valid_o = (state == ST_DONE);
endmodule

// File: rtl/rfm_checker.sv
module rfm_checker #(
  parameter int CNT_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             res_valid_o,
  input logic             res_ready_i,
  input logic [CNT_W-1:0] res_events_o,
  input logic [CNT_W-1:0] res_ticks_o,
  input logic             timeout_o
);
  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |=>
      (res_valid_o && $stable(res_events_o) && $stable(res_ticks_o)));

  // R7
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_ready_i) |=> !res_valid_o);

  // R8
  tmo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> !res_valid_o);

  // R8
  tmo_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);

  // R6
  result_sane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> (res_events_o >= CNT_W'(1) && res_ticks_o >= res_events_o));
endmodule

bind recip_freq_meter rfm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .res_valid_o  (res_valid_o),
  .res_ready_i  (res_ready_i),
  .res_events_o (res_events_o),
  .res_ticks_o  (res_ticks_o),
  .timeout_o    (timeout_o)
);

// File: tb/tb_recip_freq_meter.sv
`timescale 1ns/1ps
module tb_recip_freq_meter;
  localparam int GATE_W = 16;
  localparam int CNT_W  = GATE_W + 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [GATE_W-1:0] gate_len_i = '0;
  logic [GATE_W-1:0] timeout_len_i = '0;
  logic              sig_i;
  logic              res_valid_o;
  logic              res_ready_i = 1'b0;
  logic [CNT_W-1:0]  res_events_o;
  logic [CNT_W-1:0]  res_ticks_o;
  logic              timeout_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // stimulus generator: periodic or manual
  bit   gen_on  = 0;
  int   gen_per = 4;
  int   ph      = 0;
  logic gen_sig = 1'b0;
  logic man_sig = 1'b0;
  assign sig_i = gen_on ? gen_sig : man_sig;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (gen_on) begin
      ph      <= (ph + 1 >= gen_per) ? 0 : ph + 1;
      gen_sig <= (ph < gen_per / 2);
    end else begin
      ph      <= 0;
      gen_sig <= 1'b0;
    end
  end

  recip_freq_meter #(.GATE_W(GATE_W)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .gate_len_i    (gate_len_i),
    .timeout_len_i (timeout_len_i),
    .sig_i         (sig_i),
    .res_valid_o   (res_valid_o),
    .res_ready_i   (res_ready_i),
    .res_events_o  (res_events_o),
    .res_ticks_o   (res_ticks_o),
    .timeout_o     (timeout_o)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // One measurement with a periodic input; checks N, T, stall and stray start.
  task automatic run_meas(input string tag, input int gate, input int per,
                          input int stall, input bit stray_start);
    int g, exp_n, exp_t, waited;
    logic [CNT_W-1:0] n0, t0;
    bit seen;
    gate_len_i    = GATE_W'(gate);
    timeout_len_i = GATE_W'(1000);
    gen_per = per;
    gen_on  = 1;
    repeat (3) tick();
    pulse_start();
    if (stray_start) begin
      repeat (20) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    seen = 0;
    waited = 0;
    while (!seen && waited < 5000) begin
      tick();
      waited++;
      if (res_valid_o) seen = 1;
    end
    g = (gate == 0) ? 1 : gate;
    exp_n = g / per + 1;
    exp_t = exp_n * per;
    chk({tag, " R7 valid seen"}, seen, 1);
    chk({tag, " R5 events N"}, res_events_o, exp_n);
    chk({tag, " R4 ticks T"}, res_ticks_o, exp_t);
    n0 = res_events_o;
    t0 = res_ticks_o;
    for (int i = 0; i < stall; i++) begin
      tick();
      chk({tag, " R7 held valid"}, res_valid_o, 1);
      chk({tag, " R7 held N"}, res_events_o, n0);
      chk({tag, " R7 held T"}, res_ticks_o, t0);
    end
    @(negedge clk);
    res_ready_i = 1'b1;
    @(negedge clk);
    res_ready_i = 1'b0;
    chk({tag, " R7 drained"}, res_valid_o, 0);
    if (stray_start) begin
      seen = 0;
      for (int i = 0; i < 300; i++) begin
        tick();
        if (res_valid_o) seen = 1;
      end
      chk({tag, " R2 no second result"}, seen, 0);
    end
    gen_on = 0;
    repeat (4) tick();
  endtask

  // Armed-start timeout with a constant input level.
  task automatic run_tmo_start(input string tag, input logic level, input int tmo);
    int cnt;
    bit got, vseen;
    man_sig = level;
    gen_on  = 0;
    timeout_len_i = GATE_W'(tmo);
    gate_len_i    = GATE_W'(10);
    repeat (6) tick();
    @(negedge clk);
    start_i = 1'b1;
    cnt = 0; got = 0; vseen = 0;
    while (!got && cnt < 200) begin
      tick();
      start_i = 1'b0;
      cnt++;
      if (res_valid_o) vseen = 1;
      if (timeout_o) got = 1;
    end
    chk({tag, " R8 timeout seen"}, got, 1);
    chk({tag, " R8 timeout cycle"}, cnt, tmo + 1);
    chk({tag, " R3 no result"}, vseen, 0);
    tick();
    chk({tag, " R8 pulse width"}, timeout_o, 0);
    man_sig = 1'b0;
    repeat (4) tick();
  endtask

  // Armed-stop timeout: one lone pulse, then silence.
  task automatic run_tmo_stop();
    int cnt;
    bit got, vseen;
    gen_on = 0;
    man_sig = 1'b0;
    gate_len_i    = GATE_W'(5);
    timeout_len_i = GATE_W'(20);
    pulse_start();
    repeat (2) @(negedge clk);
    man_sig = 1'b1;
    repeat (3) @(negedge clk);
    man_sig = 1'b0;
    cnt = 0; got = 0; vseen = 0;
    while (!got && cnt < 100) begin
      tick();
      cnt++;
      if (res_valid_o) vseen = 1;
      if (timeout_o) got = 1;
    end
    chk("stop phase R8 timeout seen", got, 1);
    chk("stop phase R8 no result", vseen, 0);
    repeat (4) tick();
  endtask

  initial begin
    repeat (4) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 valid", res_valid_o, 0);
    chk("R1 timeout", timeout_o, 0);
    chk("R1 events", res_events_o, 0);
    chk("R1 ticks", res_ticks_o, 0);

    run_meas("p4g100", 100, 4, 0, 0);
    run_meas("p7g21 edge at gate end", 21, 7, 0, 0);
    run_meas("p5g0 zero gate", 0, 5, 0, 0);
    run_meas("p10g1000 stall", 1000, 10, 5, 0);
    run_meas("p6g60 stray start", 60, 6, 0, 1);
    run_meas("p200g10 single period", 10, 200, 0, 0);
    run_tmo_start("no input", 1'b0, 20);
    run_tmo_start("steady high", 1'b1, 15);
    run_tmo_stop();
    run_meas("p9g50 after timeouts", 50, 9, 0, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule